// File: doc/BRIEF.md
# Reseeding Store-and-Generate Self-Test Pattern Controller

This block drives a pseudorandom test pattern generator from a short list of stored seeds instead of letting one linear feedback shift register run freely for a very long time. A constant seed table, given as a parameter, acts as a small read-only store. An address counter picks the current seed. A pattern counter sets how many shifted patterns are produced from each seed before the next seed is loaded. Test length and hardware stay small, and faults that resist random patterns are still reached because each seed is chosen for them.

A single-cycle `start` pulse begins a session. The controller reads seed 0 and loads it in a load cycle that produces no pattern. It then runs the generator for a fixed number of cycles and repeats this for every stored seed. After the last seed it raises `done`, and the generator holds its state until the next `start`.

The generator has two variants chosen by a parameter: an external-feedback form and an internal-feedback form. The unit under test and the response compactor sit outside this block.

Top module: `seed_reseed_bist`

## Requirements
- R1: After reset the block is idle: `done`, `seed_load`, `rom_rd`, `gen_en` and `pat_valid` are low, `seed_idx` is 0 and `pattern` is 0.
- R2: A `start` pulse seen at a clock edge while idle or done makes the next cycle a load cycle. In that cycle `seed_load` and `rom_rd` are high, `seed_idx` is 0 and `pat_valid` is low.
- R3: In the cycle after a load cycle, `pat_valid` is high and `pattern` equals the seed at index `seed_idx`. Seed i is bits [i*GEN_W +: GEN_W] of the seed table.
- R4: Each seed yields exactly PATS_PER_SEED consecutive pattern cycles. In the default external-feedback variant each later pattern p' is {p[GEN_W-2:0], ^(p & FB_MASK)}.
- R5: After the last pattern of seed i, where i < NUM_SEEDS-1, the next cycle is a load cycle for seed i+1. `seed_idx` never reaches NUM_SEEDS.
- R6: After the last pattern of the last seed, `done` goes high the next cycle. From then on `pattern` holds and no strobe is raised until the next `start`.
- R7: `start` during a load cycle or a pattern cycle is ignored, and the seed and pattern sequence continues unchanged.
- R8: `start` while `done` is high restarts the session from seed 0, and `done` is low in the resulting load cycle.
- R9: `gen_en`, the generator clock enable, is high in exactly the cycles where `pat_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test session (sampled when idle or done) |
| seed_load | output | 1 | Seed is being written into the generator this cycle |
| rom_rd | output | 1 | Read strobe to the seed store |
| gen_en | output | 1 | Clock enable of the pattern generator |
| pat_valid | output | 1 | `pattern` carries a test pattern this cycle |
| pattern | output | GEN_W | Current generator state, the test pattern |
| seed_idx | output | IDX_W | Index of the current seed |
| done | output | 1 | All seeds have been applied |

## Verification
The assertions assume that `start` is a synchronous input and that it may arrive at any time, including while a session is running. They also assume that no seed in the table is zero, which elaboration rejects. The stimulus changes `start` only on the falling clock edge. It pulses `start` once from idle, again in the middle of a pattern run, again during a load cycle and finally after `done`. This covers both the cases where `start` is ignored and the case where it restarts the session.

// File: rtl/sgb_pkg.sv
package sgb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_RUN  = 2'd2,
      ST_DONE = 2'd3
   } sgb_state_e;

   localparam int GEN_EXTERNAL_FB = 0;
   localparam int GEN_INTERNAL_FB = 1;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sgb_seed_rom.sv
module sgb_seed_rom #(
   parameter int GEN_W     = 8,
   parameter int NUM_SEEDS = 4,
   parameter int IDX_W     = 2,
   parameter logic [NUM_SEEDS*GEN_W-1:0] SEED_TABLE = '1
) (
   input  logic             rd,
   input  logic [IDX_W-1:0] addr,
   output logic [GEN_W-1:0] data
);

   logic [GEN_W-1:0] rom_words [NUM_SEEDS];

   for (genvar gi = 0; gi < NUM_SEEDS; gi++) begin : g_word
      localparam logic [GEN_W-1:0] WORD = SEED_TABLE[gi*GEN_W +: GEN_W];
      if (WORD == '0) begin : g_zero_seed
         $error("sgb_seed_rom: seed %0d is zero and would lock the generator", gi);
      end
      assign rom_words[gi] = WORD;
   end

   always_comb begin
      data = '0;
      if (rd && (int'(addr) < NUM_SEEDS)) begin
         data = rom_words[addr];
      end
   end

endmodule

// File: rtl/sgb_lfsr.sv
module sgb_lfsr #(
   parameter int               GEN_W   = 8,
   parameter logic [GEN_W-1:0] FB_MASK = 8'hB8,
   parameter int               KIND    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [GEN_W-1:0] seed,
   input  logic             en,
   output logic [GEN_W-1:0] state
);

   import sgb_pkg::*;

   logic [GEN_W-1:0] state_q;
   logic [GEN_W-1:0] next_val;

   if (GEN_W < 2) begin : g_bad_width
      $error("sgb_lfsr: GEN_W must be at least 2");
   end
   if (FB_MASK == '0) begin : g_bad_mask
      $error("sgb_lfsr: feedback mask must not be zero");
   end

   if (KIND == GEN_EXTERNAL_FB) begin : g_external
      always_comb begin
         next_val = {state_q[GEN_W-2:0], ^(state_q & FB_MASK)};
      end
   end else if (KIND == GEN_INTERNAL_FB) begin : g_internal
      always_comb begin
         next_val = {state_q[GEN_W-2:0], 1'b0};
         if (state_q[GEN_W-1]) begin
            next_val = next_val ^ FB_MASK;
         end
      end
   end else begin : g_bad_kind
      $error("sgb_lfsr: unknown generator kind %0d", KIND);
      always_comb next_val = state_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else if (load) begin
         state_q <= seed;
      end else if (en) begin
         state_q <= next_val;
      end
   end

   assign state = state_q;

   AST_LOAD_TAKES_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (state_q == $past(seed)))
      else $error("seed not captured"); // R3

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !en) |=> $stable(state_q))
      else $error("generator moved without enable"); // R6

endmodule

// File: rtl/sgb_ctrl.sv
module sgb_ctrl #(
   parameter int NUM_SEEDS     = 4,
   parameter int PATS_PER_SEED = 6,
   parameter int IDX_W         = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             seed_load,
   output logic             rom_rd,
   output logic             gen_en,
   output logic             pat_valid,
   output logic             done,
   output logic [IDX_W-1:0] addr
);

   import sgb_pkg::*;

   localparam int               CNT_W     = $clog2(PATS_PER_SEED);
   localparam logic [CNT_W-1:0] PAT_LAST  = CNT_W'(PATS_PER_SEED - 1);
   localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(NUM_SEEDS - 1);

   if (PATS_PER_SEED < 2) begin : g_bad_len
      $error("sgb_ctrl: PATS_PER_SEED must be at least 2");
   end
   if (NUM_SEEDS < 1) begin : g_bad_seeds
      $error("sgb_ctrl: NUM_SEEDS must be at least 1");
   end
   if ((1 << IDX_W) < NUM_SEEDS) begin : g_bad_idx
      $error("sgb_ctrl: IDX_W too narrow for NUM_SEEDS");
   end

   sgb_state_e       state_q, state_d;
   logic [IDX_W-1:0] addr_q, addr_d;
   logic [CNT_W-1:0] pat_q, pat_d;
   logic             run_last;
   logic             seed_last;

   assign run_last  = (pat_q == PAT_LAST);
   assign seed_last = (addr_q == ADDR_LAST);

   always_comb begin
      state_d = state_q;
      addr_d  = addr_q;
      pat_d   = pat_q;
      unique case (state_q)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               state_d = ST_LOAD;
               addr_d  = '0;
               pat_d   = '0;
            end
         end
         ST_LOAD: begin
            state_d = ST_RUN;
            pat_d   = '0;
         end
         ST_RUN: begin
            if (run_last) begin
               pat_d = '0;
               if (seed_last) begin
                  state_d = ST_DONE;
               end else begin
                  state_d = ST_LOAD;
                  addr_d  = addr_q + 1'b1;
               end
            end else begin
               pat_d = pat_q + 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         pat_q   <= '0;
      end else begin
         state_q <= state_d;
         addr_q  <= addr_d;
         pat_q   <= pat_d;
      end
   end

   assign seed_load = (state_q == ST_LOAD);
   assign rom_rd    = (state_q == ST_LOAD);
   assign gen_en    = (state_q == ST_RUN);
   assign pat_valid = (state_q == ST_RUN);
   assign done      = (state_q == ST_DONE);
   assign addr      = addr_q;

   AST_PAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pat_q <= PAT_LAST)
      else $error("pattern counter beyond run length"); // R4

   AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(addr_q) < NUM_SEEDS)
      else $error("seed address out of range"); // R5

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid |=> (!seed_load || (addr_q == IDX_W'($past(addr_q) + 1'b1))))
      else $error("seed address did not advance by one"); // R5

   AST_LOAD_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> (pat_valid && $stable(addr_q)))
      else $error("load not followed by pattern run"); // R3

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_valid && start && !run_last) |=> (pat_valid && $stable(addr_q)))
      else $error("start disturbed a running session"); // R7

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done)
      else $error("done dropped without start"); // R6

   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (seed_load && !done && (addr_q == '0)))
      else $error("restart did not load seed 0"); // R8

endmodule

// File: rtl/seed_reseed_bist.sv
module seed_reseed_bist #(
   parameter int                           GEN_W         = 8,
   parameter int                           NUM_SEEDS     = 4,
   parameter int                           PATS_PER_SEED = 6,
   parameter logic [GEN_W-1:0]             FB_MASK       = 8'hB8,
   parameter int                           GEN_KIND      = 0,
   parameter logic [NUM_SEEDS*GEN_W-1:0]   SEED_TABLE    = 32'hA5_3C_81_17,
   localparam int                          IDX_W         = sgb_pkg::idx_width(NUM_SEEDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             seed_load,
   output logic             rom_rd,
   output logic             gen_en,
   output logic             pat_valid,
   output logic [GEN_W-1:0] pattern,
   output logic [IDX_W-1:0] seed_idx,
   output logic             done
);

   logic [GEN_W-1:0] rom_data;
   logic             load_s;
   logic             rd_s;
   logic             en_s;
   logic [IDX_W-1:0] addr_s;

   sgb_ctrl #(
      .NUM_SEEDS    (NUM_SEEDS),
      .PATS_PER_SEED(PATS_PER_SEED),
      .IDX_W        (IDX_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .seed_load(load_s),
      .rom_rd   (rd_s),
      .gen_en   (en_s),
      .pat_valid(pat_valid),
      .done     (done),
      .addr     (addr_s)
   );

   sgb_seed_rom #(
      .GEN_W     (GEN_W),
      .NUM_SEEDS (NUM_SEEDS),
      .IDX_W     (IDX_W),
      .SEED_TABLE(SEED_TABLE)
   ) u_rom (
      .rd  (rd_s),
      .addr(addr_s),
      .data(rom_data)
   );

   sgb_lfsr #(
      .GEN_W  (GEN_W),
      .FB_MASK(FB_MASK),
      .KIND   (GEN_KIND)
   ) u_gen (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load_s),
      .seed (rom_data),
      .en   (en_s),
      .state(pattern)
   );

   assign seed_load = load_s;
   assign rom_rd    = rd_s;
   assign gen_en    = en_s;
   assign seed_idx  = addr_s;

   AST_FIRST_LOAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      ((!seed_load && !pat_valid) && start) |=> (seed_load && seed_idx == '0))
      else $error("start did not open with seed 0"); // R2

   AST_PATTERN_IS_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> (pattern == $past(rom_data)))
      else $error("first pattern is not the stored seed"); // R3

endmodule

// File: tb/seed_reseed_bist_tb.sv
module seed_reseed_bist_tb;

   localparam int                          CLK_PERIOD = 10;
   localparam int                          W          = 8;
   localparam int                          N          = 4;
   localparam int                          L          = 6;
   localparam logic [W-1:0]                TAPS       = 8'hB8;
   localparam logic [N*W-1:0]              TABLE      = 32'hA5_3C_81_17;
   localparam int                          AW         = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          seed_load, rom_rd, gen_en, pat_valid, done;
   logic [W-1:0]  pattern;
   logic [AW-1:0] seed_idx;

   typedef struct packed {
      logic [W-1:0]  pat;
      logic [AW-1:0] idx;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   exp_load_idx;
   int   run_len;
   bit   mon_on = 1'b0;
   bit   reported = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seed_reseed_bist #(
      .GEN_W(W), .NUM_SEEDS(N), .PATS_PER_SEED(L),
      .FB_MASK(TAPS), .GEN_KIND(0), .SEED_TABLE(TABLE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .seed_load(seed_load), .rom_rd(rom_rd), .gen_en(gen_en),
      .pat_valid(pat_valid), .pattern(pattern), .seed_idx(seed_idx),
      .done(done)
   );

   function automatic logic [W-1:0] step(input logic [W-1:0] p);
      return {p[W-2:0], ^(p & TAPS)};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      end
   endtask

   // Driver side: queue every pattern the session must produce
   task automatic push_expected();
      for (int n = 0; n < N; n++) begin
         logic [W-1:0] p;
         p = TABLE[n*W +: W];
         for (int k = 0; k < L; k++) begin
            exp_q.push_back({p, AW'(n)});
            p = step(p);
         end
      end
      exp_load_idx = 0;
      run_len      = 0;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic check_finish(input string tag);
      check("R6", {tag, " queue drained"}, exp_q.size(), 0);
      check("R6", {tag, " last run length"}, run_len, L);
      check("R5", {tag, " seeds loaded"}, exp_load_idx, N);
   endtask

   task automatic check_hold();
      logic [W-1:0] held;
      held = pattern;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R6", "done held", done, 1);
         check("R6", "pattern held", pattern, held);
         check("R6", "no load strobe", seed_load, 0);
         check("R6", "no pattern strobe", pat_valid, 0);
      end
   endtask

   // Monitor side: pop and compare as the design produces results
   always @(negedge clk) begin
      if (mon_on) begin
         check("R9", "gen_en vs pat_valid", gen_en, pat_valid);
         if (seed_load) begin
            check("R2", "rom_rd on load", rom_rd, 1);
            check("R2", "no pattern on load", pat_valid, 0);
            check("R5", "load index", seed_idx, exp_load_idx);
            if (exp_load_idx != 0) check("R4", "patterns per seed", run_len, L);
            exp_load_idx++;
            run_len = 0;
         end
         if (pat_valid) begin
            if (exp_q.size() == 0) begin
               check("R4", "unexpected pattern", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R3/R4", "pattern value", pattern, e.pat);
               check("R3", "pattern seed index", seed_idx, e.idx);
            end
            run_len++;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected done");
      report();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "done", done, 0);
      check("R1", "seed_load", seed_load, 0);
      check("R1", "rom_rd", rom_rd, 0);
      check("R1", "gen_en", gen_en, 0);
      check("R1", "pat_valid", pat_valid, 0);
      check("R1", "seed_idx", seed_idx, 0);
      check("R1", "pattern", pattern, 0);
      mon_on = 1'b1;

      // Session 1 from idle, with ignored start pulses (R7)
      push_expected();
      pulse_start();
      check("R2", "load after start", seed_load, 1);
      check("R2", "first index", seed_idx, 0);
      repeat (3) @(negedge clk);
      pulse_start();                       // R7: mid-run pulse
      while (!seed_load) @(negedge clk);
      pulse_start();                       // R7: pulse during a load cycle
      wait_done();
      check_finish("run1");
      check_hold();

      // Session 2: restart from done (R8)
      push_expected();
      pulse_start();
      check("R8", "done low on restart load", done, 0);
      check("R8", "restart load", seed_load, 1);
      check("R8", "restart index", seed_idx, 0);
      wait_done();
      check_finish("run2");
      check_hold();

      report();
      $finish;
   end

endmodule